// File: doc/BRIEF.md
# Serial Command Target with Write-Arm Latch

This block is a serial peripheral target that receives a one-byte command at the start of every chip-select frame. It holds a single write-arm latch, which must be set before a register write is accepted. A completed write uses up the latch. The block also holds one 8-bit target register. Four commands are decoded: arm, disarm, status read, and register write. A write carries an 8-bit address byte and then an 8-bit data byte.

The serial clock, chip select and data input are synchronized into the system clock, and edges are detected there, so all state lives in one clock domain. Input bits are taken on rising serial-clock edges. Output bits change after falling edges. Clock polarity 0 and 3 both work without any configuration. The serial output comes as a data bit and a separate output enable. The enable drops as soon as chip select rises.

Top module: `spi_wel_target`

## Requirements
- R1: Both idle clock levels (mode 0, idle low; mode 3, idle high) work. Input is captured on rising serial-clock edges, and output bits update after falling edges, so they are stable before the next rising edge.
- R2: Bytes travel most significant bit first. The command byte is the first 8 rising edges after chip select falls. The command codes are 0x06 arm, 0x04 disarm, 0x05 status read and 0x02 write.
- R3: `spi_miso_oe` is low whenever `spi_cs_n` is high, including during and after reset. It is high only while status bits are being returned.
- R4: Command 0x06 sets the write-arm latch and command 0x04 clears it. Reset clears it.
- R5: Command 0x05 returns a status byte with the latch in bit 1 and all other bits 0. Every further byte in the same frame repeats the status.
- R6: Command 0x02 with the latch set, followed by address REG_ADDR (default 0x10) and 8 data bits, loads the data into `reg_value`. The completed write then clears the latch.
- R7: A write command received while the latch is clear leaves `reg_value` and the latch unchanged.
- R8: Raising chip select before the 8th data bit of a write commits nothing and leaves the latch set.
- R9: After an arm or disarm command, all further bytes in that frame are ignored until chip select rises.
- R10: An unsupported command byte has no effect. The rest of that frame is ignored and the output stays disabled.
- R11: A completed armed write to an address other than REG_ADDR leaves `reg_value` unchanged but still clears the latch.
- R12: Reset loads `reg_value` with RESET_VAL (default 0x00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out bit |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| reg_value | output | 8 | Target register contents |

## Verification
A latch stuck set or stuck clear shows in the next status-read frame as a wrong bit 1. It also shows as a write that lands or vanishes on `reg_value` about four system clocks after the 8th data bit. A wrong bit count or a wrong shift order appears at once, either as a corrupted status byte or as a wrong register value. A control state that fails to stick after an arm command shows as a second command in the same frame taking effect, which a later status read exposes.

// File: rtl/spi_wel_pkg.sv
package spi_wel_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_ARM    = 8'h06;
  localparam logic [BYTE_W-1:0] OP_DISARM = 8'h04;
  localparam logic [BYTE_W-1:0] OP_STATUS = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h02;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_READ,
    PH_HOLD
  } phase_t;

  function automatic logic [BYTE_W-1:0] status_byte(input logic armed);
    status_byte = {{(BYTE_W-2){1'b0}}, armed, 1'b0};
  endfunction
endpackage

// File: rtl/spi_wel_sync.sv
module spi_wel_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic frame_on,
  output logic mosi_s
);
  logic [STAGES:0]   sclk_q, sclk_d;
  logic [STAGES-1:0] cs_q, cs_d;
  logic [STAGES-1:0] mosi_q, mosi_d;

  always_comb begin
    sclk_d = {sclk_q[STAGES-1:0], spi_sclk};
    cs_d   = {cs_q[STAGES-2:0], spi_cs_n};
    mosi_d = {mosi_q[STAGES-2:0], spi_mosi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      mosi_q <= mosi_d;
    end
  end

  assign frame_on  = ~cs_q[STAGES-1];
  assign sclk_rise = frame_on &  sclk_q[STAGES-1] & ~sclk_q[STAGES];
  assign sclk_fall = frame_on & ~sclk_q[STAGES-1] &  sclk_q[STAGES];
  assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/spi_wel_shift.sv
module spi_wel_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_on,
  input  logic         sclk_rise,
  input  logic         mosi_s,
  output logic         byte_done,
  output logic [W-1:0] rx_byte
);
  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-2:0]  sr_q, sr_d;
  logic          en;

  assign byte_done = sclk_rise & (cnt_q == CW'(W-1));
  assign rx_byte   = {sr_q, mosi_s};
  assign en        = sclk_rise | ~frame_on;

  always_comb begin
    cnt_d = cnt_q;
    sr_d  = sr_q;
    if (!frame_on) begin
      cnt_d = '0;
      sr_d  = '0;
    end else if (sclk_rise) begin
      cnt_d = byte_done ? '0 : cnt_q + CW'(1);
      sr_d  = {sr_q[W-3:0], mosi_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
    end
  end
endmodule

// File: rtl/spi_wel_tx.sv
module spi_wel_tx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         sclk_fall,
  output logic         miso_bit
);
  logic [W-1:0] sr_q, sr_d;
  logic         bit_q, bit_d;
  logic         en;

  assign en = load | (shift_en & sclk_fall);

  always_comb begin
    sr_d  = sr_q;
    bit_d = bit_q;
    if (load) begin
      sr_d = load_val;
    end else if (shift_en && sclk_fall) begin
      bit_d = sr_q[W-1];
      sr_d  = {sr_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      bit_q <= 1'b0;
    end else if (en) begin
      sr_q  <= sr_d;
      bit_q <= bit_d;
    end
  end

  assign miso_bit = bit_q;
endmodule

// File: rtl/spi_wel_ctrl.sv
module spi_wel_ctrl
  import spi_wel_pkg::*;
#(
  parameter logic [7:0] REG_ADDR  = 8'h10,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_on,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  output phase_t     phase,
  output logic       armed,
  output logic [7:0] reg_q,
  output logic       tx_load,
  output logic [7:0] tx_val
);
  phase_t     ph_q, ph_d;
  logic       arm_q, arm_d;
  logic [7:0] reg_d, reg_r;
  logic [7:0] addr_q, addr_d;

  always_comb begin
    ph_d    = ph_q;
    arm_d   = arm_q;
    reg_d   = reg_r;
    addr_d  = addr_q;
    tx_load = 1'b0;
    if (!frame_on) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE: ph_d = PH_CMD;
        PH_CMD: if (byte_done) begin
          case (rx_byte)
            OP_ARM:    begin arm_d = 1'b1; ph_d = PH_HOLD; end
            OP_DISARM: begin arm_d = 1'b0; ph_d = PH_HOLD; end
            OP_STATUS: begin tx_load = 1'b1; ph_d = PH_READ; end
            OP_WRITE:  ph_d = arm_q ? PH_ADDR : PH_HOLD;
            default:   ph_d = PH_HOLD;
          endcase
        end
        PH_ADDR: if (byte_done) begin
          addr_d = rx_byte;
          ph_d   = PH_DATA;
        end
        PH_DATA: if (byte_done) begin
          if (addr_q == REG_ADDR) reg_d = rx_byte;
          arm_d = 1'b0;
          ph_d  = PH_HOLD;
        end
        PH_READ: if (byte_done) tx_load = 1'b1;
        default: ph_d = PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      arm_q  <= 1'b0;
      reg_r  <= RESET_VAL;
      addr_q <= '0;
    end else begin
      ph_q   <= ph_d;
      arm_q  <= arm_d;
      reg_r  <= reg_d;
      addr_q <= addr_d;
    end
  end

  assign phase  = ph_q;
  assign armed  = arm_q;
  assign reg_q  = reg_r;
  assign tx_val = status_byte(arm_q);
endmodule

// File: rtl/spi_wel_target.sv
module spi_wel_target
  import spi_wel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  REG_ADDR    = 8'h10,
  parameter logic [7:0]  RESET_VAL   = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  output logic [7:0] reg_value
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;
  logic       sclk_rise, sclk_fall, frame_on, mosi_s;
  logic       byte_done, tx_load;
  logic [7:0] rx_byte, tx_val;
  phase_t     phase_q;
  logic       wel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  spi_wel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .frame_on(frame_on), .mosi_s(mosi_s)
  );

  spi_wel_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n_i), .frame_on(frame_on), .sclk_rise(sclk_rise),
    .mosi_s(mosi_s), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  spi_wel_ctrl #(.REG_ADDR(REG_ADDR), .RESET_VAL(RESET_VAL)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .frame_on(frame_on), .byte_done(byte_done),
    .rx_byte(rx_byte), .phase(phase_q), .armed(wel_q), .reg_q(reg_value),
    .tx_load(tx_load), .tx_val(tx_val)
  );

  spi_wel_tx #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n_i), .load(tx_load), .load_val(tx_val),
    .shift_en(phase_q == PH_READ), .sclk_fall(sclk_fall), .miso_bit(spi_miso)
  );

  assign spi_miso_oe = (phase_q == PH_READ) & ~spi_cs_n;
endmodule

// File: rtl/spi_wel_target_chk.sv
module spi_wel_target_chk
  import spi_wel_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       wel,
  input logic [7:0] reg_value,
  input phase_t     phase
);
  a_r6_commit_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_value != $past(reg_value)) |-> $past(wel));

  a_r6_commit_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_value != $past(reg_value)) |-> !wel);

  a_r4_arm_from_command: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> ($past(phase) == PH_CMD));

  a_r9_hold_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |=> (phase == PH_HOLD || phase == PH_IDLE));

  a_r8_deselect_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && $past(spi_cs_n, 4))
      |-> (phase == PH_IDLE));
endmodule

bind spi_wel_target spi_wel_target_chk u_chk (
  .clk(clk), .rst_n(rst_n_i), .spi_cs_n(spi_cs_n), .wel(wel_q),
  .reg_value(reg_value), .phase(phase_q)
);

// File: tb/spi_wel_target_test.sv
module spi_wel_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam logic [7:0] TGT_ADDR = 8'h10;
  localparam logic [7:0] RST_VAL  = 8'h00;

  logic clk = 1'b0;
  logic rst_n, spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso, spi_miso_oe;
  logic [7:0] reg_value;

  int checks = 0, failures = 0;
  bit done = 0;
  bit mode3 = 0;
  bit m_wel;
  logic [7:0] m_reg;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_wel_target uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .reg_value(reg_value)
  );

  function automatic logic [7:0] exp_status(input bit w);
    return {6'b0, w, 1'b0};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_open();
    spi_sclk = mode3;
    wait_clk(HALF);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic frame_close();
    if (!mode3) spi_sclk = 1'b0;
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    #1;
    check("R3 oe low at deselect", {7'b0, spi_miso_oe}, 8'h00);
    wait_clk(8);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx, output bit oe_all);
    rx = '0;
    oe_all = 1;
    for (int i = 0; i < nbits; i++) begin
      spi_sclk = 1'b0;
      spi_mosi = tx[7-i];
      wait_clk(HALF);
      rx[7-i] = spi_miso;
      oe_all &= spi_miso_oe;
      spi_sclk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic op_simple(input logic [7:0] opc, input bit extra, input logic [7:0] ex);
    logic [7:0] r; bit oe;
    frame_open();
    xfer(opc, 8, r, oe);
    if (extra) xfer(ex, 8, r, oe);
    frame_close();
  endtask

  task automatic op_arm(input bit extra, input logic [7:0] ex);
    op_simple(8'h06, extra, ex);
    m_wel = 1;
  endtask

  task automatic op_disarm();
    op_simple(8'h04, 0, 8'h00);
    m_wel = 0;
  endtask

  task automatic op_write(input logic [7:0] a, input logic [7:0] d, input int dbits);
    logic [7:0] r; bit oe;
    frame_open();
    xfer(8'h02, 8, r, oe);
    xfer(a, 8, r, oe);
    xfer(d, dbits, r, oe);
    frame_close();
    if (dbits == 8 && m_wel) begin
      if (a == TGT_ADDR) m_reg = d;
      m_wel = 0;
    end
  endtask

  task automatic op_status(input string req);
    logic [7:0] r; bit oe;
    frame_open();
    xfer(8'h05, 8, r, oe);
    xfer(8'h00, 8, r, oe);
    check({req, " status byte"}, r, exp_status(m_wel));
    check("R3 oe high during status", {7'b0, oe}, 8'h01);
    xfer(8'hFF, 8, r, oe);
    check("R5 repeated status byte", r, exp_status(m_wel));
    frame_close();
  endtask

  task automatic check_reg(input string req);
    check(req, reg_value, m_reg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r; bit oe;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst_n = 0; spi_sclk = 0; spi_cs_n = 1; spi_mosi = 0;
    m_wel = 0; m_reg = RST_VAL;
    wait_clk(3);
    check("R3 oe low in reset", {7'b0, spi_miso_oe}, 8'h00);
    rst_n = 1;
    wait_clk(5);
    check("R12 reset value", reg_value, RST_VAL);
    op_status("R4 reset clears latch");

    // R1 mode 0 then mode 3, R2/R6 write commits and clears latch
    op_arm(0, 8'h00);
    op_status("R4 arm sets latch");
    op_write(TGT_ADDR, 8'hA5, 8);
    check_reg("R6 armed write mode0");
    op_status("R6 latch cleared after write");
    mode3 = 1;
    op_arm(0, 8'h00);
    op_write(TGT_ADDR, 8'h3C, 8);
    check_reg("R1 armed write mode3");
    op_status("R1 status in mode3");
    mode3 = 0;
    // R7 write without arming
    op_write(TGT_ADDR, 8'h77, 8);
    check_reg("R7 unarmed write ignored");
    // R8 aborted write
    op_arm(0, 8'h00);
    op_write(TGT_ADDR, 8'h99, 5);
    check_reg("R8 aborted write commits nothing");
    op_status("R8 latch kept after abort");
    // R9 second command after arm ignored
    op_disarm();
    op_arm(1, 8'h04);
    op_status("R9 disarm in hold ignored");
    // R10 invalid opcode then disarm ignored
    frame_open();
    xfer(8'hFF, 8, r, oe);
    xfer(8'h04, 8, r, oe);
    check("R10 oe stays low", {7'b0, oe}, 8'h00);
    frame_close();
    op_status("R10 invalid opcode no effect");
    // R11 other address
    op_write(8'h11, 8'h5A, 8);
    check_reg("R11 other address no change");
    op_status("R11 latch cleared");

    for (int k = 0; k < 60; k++) begin
      int unsigned sel;
      logic [7:0] ad;
      mode3 = $urandom_range(0, 1) != 0;
      sel = $urandom_range(0, 5);
      ad = ($urandom_range(0, 3) != 0) ? TGT_ADDR : 8'($urandom);
      case (sel)
        0: op_arm($urandom_range(0, 1) != 0, 8'($urandom));
        1: op_disarm();
        2: op_write(ad, 8'($urandom), 8);
        3: op_write(ad, 8'($urandom), $urandom_range(1, 7));
        4: op_status("R5 random status");
        default: begin
          logic [7:0] bad;
          bad = 8'($urandom) | 8'h80;
          op_simple(bad, 1, 8'h06);
        end
      endcase
      check_reg("R6 random register tracking");
    end
    op_status("R4 final latch state");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule